// File: doc/BRIEF.md
# Bit Test and Modify Unit

This unit runs the four single-bit operations on a 16-bit operand: test, test-and-set, test-and-reset and test-and-complement. The operand is either a register value given on the ports or a word in memory, reached through a simple request/acknowledge port. The bit offset comes from a 16-bit register or from an 8-bit immediate. Carry receives the selected bit as it was before any change. For register operands the unit returns the updated word with a write strobe. For memory operands it reads the word and, if the operation modifies it, writes it back.

With a register-supplied offset and a memory operand, the offset is split into two parts. The low four bits pick the bit. The upper twelve bits are a signed displacement in words from the base effective address. Any bit in a ±2K-word window around the base can therefore be reached. The final address is always ANDed with an address-size mask before it is issued. Other flags are left to the caller and never change here.

Top module: `bit_test_unit`

## Requirements
- R1: While rst_ni is low and right after reset, done_o, cf_o, reg_we_o and mem_req_o are 0.
- R2: On done_o, cf_o equals the selected bit of the operand as it was before modification, for every operation.
- R3: op_i encodes 0 = test (word unchanged), 1 = set (bit forced to 1), 2 = reset (bit forced to 0), 3 = complement (bit inverted). No other bit of the word changes.
- R4: For a register operand with a register offset, only off_reg_i[3:0] picks the bit; off_reg_i[15:4] has no effect.
- R5: When imm_i is 1, the bit is picked by off_imm_i[3:0] alone, for both register and memory operands.
- R6: A register operand (mem_i = 0) raises done_o exactly one cycle after start_i and never asserts mem_req_o. reg_result_o holds the new word, and reg_we_o is 1 only during done_o and only for ops 1 to 3.
- R7: For a memory operand with a register offset, mem_addr_o = (base_addr_i + 2 × signext(off_reg_i[15:4])) & addr_mask_i, with 32-bit wraparound.
- R8: For a memory operand with an immediate offset, mem_addr_o = base_addr_i & addr_mask_i.
- R9: Test on memory issues one read (mem_we_o = 0) only. Ops 1 to 3 issue a read and then a write (mem_we_o = 1) of the modified word to the same address.
- R10: mem_req_o and mem_addr_o stay steady until mem_ack_i. done_o pulses for one cycle, one cycle after the last acknowledge. start_i is ignored while an operation is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (sampled while idle) |
| op_i | input | 2 | Operation code |
| mem_i | input | 1 | 1 = memory operand, 0 = register operand |
| imm_i | input | 1 | 1 = offset from off_imm_i, 0 = from off_reg_i |
| reg_val_i | input | 16 | Register operand value |
| off_reg_i | input | 16 | Register bit offset |
| off_imm_i | input | 8 | Immediate bit offset |
| base_addr_i | input | 32 | Base effective address |
| addr_mask_i | input | 32 | Address-size mask |
| done_o | output | 1 | Operation complete (one-cycle pulse) |
| cf_o | output | 1 | Carry result |
| reg_result_o | output | 16 | Updated register value |
| reg_we_o | output | 1 | Register write strobe |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 32 | Memory address |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rdata_i | input | 16 | Memory read data |
| mem_ack_i | input | 1 | Memory acknowledge |

## Verification
The assertions assume that mem_ack_i is raised only while mem_req_o is high. They also assume that addr_mask_i holds steady from start_i until done_o, because the address-mask property compares the issued address with the live mask. The stimulus keeps to both assumptions: the memory responder acknowledges one cycle after it sees a request, and every operation's mask is driven as a constant for its whole run.

// File: rtl/bit_test_pkg.sv
package bit_test_pkg;
  typedef enum logic [1:0] {
    BT_TEST  = 2'd0,
    BT_SET   = 2'd1,
    BT_RESET = 2'd2,
    BT_COMP  = 2'd3
  } bt_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_DONE
  } bt_state_e;
endpackage

// File: rtl/bit_test_addr.sv
module bit_test_addr #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 8,
  localparam int IDX_W  = $clog2(DATA_W),
  localparam int DISP_W = DATA_W - IDX_W,
  localparam int SHIFT  = $clog2(DATA_W / 8)
) (
  input  logic [DATA_W-1:0] off_reg_i,
  input  logic [IMM_W-1:0]  off_imm_i,
  input  logic              imm_sel_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] mask_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [DISP_W-1:0] disp;
  logic [ADDR_W-1:0] disp_ext;
  logic [ADDR_W-1:0] raw_addr;

  assign disp     = off_reg_i[DATA_W-1:IDX_W];
  assign disp_ext = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp} << SHIFT;
  assign raw_addr = imm_sel_i ? base_i : base_i + disp_ext;
  assign addr_o   = raw_addr & mask_i;
  assign idx_o    = imm_sel_i ? off_imm_i[IDX_W-1:0] : off_reg_i[IDX_W-1:0];
endmodule

// File: rtl/bit_test_alu.sv
module bit_test_alu
  import bit_test_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] word_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  bt_op_e            op_i,
  output logic              cf_o,
  output logic [DATA_W-1:0] word_o
);
  assign cf_o = word_i[idx_i];

  for (genvar g = 0; g < DATA_W; g++) begin : g_bit
    logic hit;
    assign hit = (idx_i == IDX_W'(g));
    always_comb begin
      word_o[g] = word_i[g];
      if (hit) begin
        unique case (op_i)
          BT_SET:   word_o[g] = 1'b1;
          BT_RESET: word_o[g] = 1'b0;
          BT_COMP:  word_o[g] = ~word_i[g];
          default:  word_o[g] = word_i[g];
        endcase
      end
    end
  end
endmodule

// File: rtl/bit_test_ctrl.sv
module bit_test_ctrl
  import bit_test_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  logic      mem_i,
  input  logic      is_test_i,
  input  logic      ack_i,
  output bt_state_e state_o
);
  bt_state_e state_d;

  always_comb begin
    state_d = state_o;
    unique case (state_o)
      ST_IDLE:  if (start_i) state_d = mem_i ? ST_READ : ST_DONE;
      ST_READ:  if (ack_i) state_d = is_test_i ? ST_DONE : ST_WRITE;
      ST_WRITE: if (ack_i) state_d = ST_DONE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_o <= ST_IDLE;
    else         state_o <= state_d;
  end
endmodule

// File: rtl/bit_test_unit.sv
module bit_test_unit
  import bit_test_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic              mem_i,
  input  logic              imm_i,
  input  logic [DATA_W-1:0] reg_val_i,
  input  logic [DATA_W-1:0] off_reg_i,
  input  logic [IMM_W-1:0]  off_imm_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [ADDR_W-1:0] addr_mask_i,
  output logic              done_o,
  output logic              cf_o,
  output logic [DATA_W-1:0] reg_result_o,
  output logic              reg_we_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ack_i
);
  bt_state_e         state_q;
  bt_op_e            op_q;
  logic [IDX_W-1:0]  idx_q, idx_c;
  logic [ADDR_W-1:0] addr_q, addr_c;
  logic              cf_q, reg_we_q;
  logic [DATA_W-1:0] word_q;

  logic              idle, launch, rd_ack;
  logic [DATA_W-1:0] alu_in, alu_out;
  logic [IDX_W-1:0]  alu_idx;
  bt_op_e            alu_op;
  logic              alu_cf;

  assign idle   = (state_q == ST_IDLE);
  assign launch = idle && start_i;
  assign rd_ack = (state_q == ST_READ) && mem_ack_i;

  bit_test_addr #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_addr (
    .off_reg_i (off_reg_i),
    .off_imm_i (off_imm_i),
    .imm_sel_i (imm_i),
    .base_i    (base_addr_i),
    .mask_i    (addr_mask_i),
    .idx_o     (idx_c),
    .addr_o    (addr_c)
  );

  // one ALU serves the register path at launch and the memory path at read ack
  assign alu_in  = idle ? reg_val_i : mem_rdata_i;
  assign alu_idx = idle ? idx_c : idx_q;
  assign alu_op  = idle ? bt_op_e'(op_i) : op_q;

  bit_test_alu #(.DATA_W(DATA_W)) u_alu (
    .word_i (alu_in),
    .idx_i  (alu_idx),
    .op_i   (alu_op),
    .cf_o   (alu_cf),
    .word_o (alu_out)
  );

  bit_test_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .mem_i     (mem_i),
    .is_test_i (op_q == BT_TEST),
    .ack_i     (mem_ack_i),
    .state_o   (state_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q     <= BT_TEST;
      idx_q    <= '0;
      addr_q   <= '0;
      cf_q     <= 1'b0;
      word_q   <= '0;
      reg_we_q <= 1'b0;
    end else if (launch) begin
      op_q     <= bt_op_e'(op_i);
      idx_q    <= idx_c;
      addr_q   <= addr_c;
      reg_we_q <= !mem_i && (bt_op_e'(op_i) != BT_TEST);
      if (!mem_i) begin
        cf_q   <= alu_cf;
        word_q <= alu_out;
      end
    end else if (rd_ack) begin
      cf_q   <= alu_cf;
      word_q <= alu_out;
    end
  end

  assign done_o       = (state_q == ST_DONE);
  assign cf_o         = cf_q;
  assign reg_result_o = word_q;
  assign reg_we_o     = done_o && reg_we_q;
  assign mem_req_o    = (state_q == ST_READ) || (state_q == ST_WRITE);
  assign mem_we_o     = (state_q == ST_WRITE);
  assign mem_addr_o   = addr_q;
  assign mem_wdata_o  = word_q;
endmodule

// File: rtl/bit_test_unit_chk.sv
module bit_test_unit_chk
  import bit_test_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              mem_i,
  input logic              mem_ack_i,
  input logic [ADDR_W-1:0] addr_mask_i,
  input logic              done_o,
  input logic              reg_we_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input bt_state_e         state_i,
  input bt_op_e            op_q_i
);
  // R6
  reg_op_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IDLE && start_i && !mem_i) |=> (done_o && !mem_req_o));

  // R6
  reg_we_in_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> done_o);

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R10
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));

  // R9
  test_read_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_READ && mem_ack_i && op_q_i == BT_TEST) |=> (done_o && !mem_req_o));

  // R9
  write_same_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_o) |-> $stable(mem_addr_o));

  // R7
  addr_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> ((mem_addr_o & ~addr_mask_i) == '0));
endmodule

bind bit_test_unit bit_test_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .mem_i       (mem_i),
  .mem_ack_i   (mem_ack_i),
  .addr_mask_i (addr_mask_i),
  .done_o      (done_o),
  .reg_we_o    (reg_we_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .state_i     (state_q),
  .op_q_i      (op_q)
);

// File: tb/bit_test_unit_bench.sv
module bit_test_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  op = '0;
  logic        mem = 1'b0, imm = 1'b0;
  logic [15:0] reg_val = '0, off_reg = '0, rdata = '0;
  logic [7:0]  off_imm = '0;
  logic [31:0] base = '0, mask = '1;
  logic        ack = 1'b0;
  logic        done, cf, reg_we, req, we;
  logic [15:0] reg_res, wdata;
  logic [31:0] addr;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  bit_test_unit u_bit_test_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .mem_i(mem), .imm_i(imm),
    .reg_val_i(reg_val), .off_reg_i(off_reg), .off_imm_i(off_imm), .base_addr_i(base),
    .addr_mask_i(mask), .done_o(done), .cf_o(cf), .reg_result_o(reg_res), .reg_we_o(reg_we),
    .mem_req_o(req), .mem_we_o(we), .mem_addr_o(addr), .mem_wdata_o(wdata),
    .mem_rdata_i(rdata), .mem_ack_i(ack)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic        mem;
    logic        imm;
    logic [15:0] reg_val;
    logic [15:0] off_reg;
    logic [7:0]  off_imm;
    logic [31:0] base;
    logic [31:0] mask;
    logic [15:0] rdata;
    logic        cf;
    logic [15:0] word;
    logic [31:0] addr;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    // R3 test, register
    '{2'd0, 1'b0, 1'b0, 16'h0010, 16'h0004, 8'h00, 32'h0, 32'hFFFFFFFF, 16'h0, 1'b1, 16'h0010, 32'h0},
    // R4 set, upper offset bits ignored
    '{2'd1, 1'b0, 1'b0, 16'h0000, 16'hFFF3, 8'h00, 32'h0, 32'hFFFFFFFF, 16'h0, 1'b0, 16'h0008, 32'h0},
    // R3 reset top bit
    '{2'd2, 1'b0, 1'b0, 16'hFFFF, 16'h000F, 8'h00, 32'h0, 32'hFFFFFFFF, 16'h0, 1'b1, 16'h7FFF, 32'h0},
    // R5 complement, immediate upper bits ignored
    '{2'd3, 1'b0, 1'b1, 16'h00F0, 16'hFFFF, 8'hF5, 32'h0, 32'hFFFFFFFF, 16'h0, 1'b1, 16'h00D0, 32'h0},
    // R3 complement bit 0
    '{2'd3, 1'b0, 1'b0, 16'h1234, 16'h0000, 8'h00, 32'h0, 32'hFFFFFFFF, 16'h0, 1'b0, 16'h1235, 32'h0},
    // R3 set on already-set bit
    '{2'd1, 1'b0, 1'b0, 16'h0008, 16'h0003, 8'h00, 32'h0, 32'hFFFFFFFF, 16'h0, 1'b1, 16'h0008, 32'h0},
    // R7 test memory, displacement +2 words
    '{2'd0, 1'b1, 1'b0, 16'h0, 16'h0025, 8'h00, 32'h00001000, 32'hFFFFFFFF, 16'h0020, 1'b1, 16'h0020, 32'h00001004},
    // R7 set memory, displacement -1 word
    '{2'd1, 1'b1, 1'b0, 16'h0, 16'hFFF7, 8'h00, 32'h00001000, 32'hFFFFFFFF, 16'h0000, 1'b0, 16'h0080, 32'h00000FFE},
    // R8 reset memory, immediate
    '{2'd2, 1'b1, 1'b1, 16'h0, 16'hFFF0, 8'h2C, 32'h00002002, 32'hFFFFFFFF, 16'hF000, 1'b1, 16'hE000, 32'h00002002},
    // R7 complement memory, most negative displacement, masked
    '{2'd3, 1'b1, 1'b0, 16'h0, 16'h8001, 8'h00, 32'h00010000, 32'h0000FFFF, 16'h0002, 1'b1, 16'h0000, 32'h0000F000},
    // R8 test memory, immediate, masked
    '{2'd0, 1'b1, 1'b1, 16'h0, 16'h1230, 8'h0F, 32'h80004444, 32'h0000FFFF, 16'h8000, 1'b1, 16'h8000, 32'h00004444}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    op = v.op; mem = v.mem; imm = v.imm; reg_val = v.reg_val;
    off_reg = v.off_reg; off_imm = v.off_imm; base = v.base; mask = v.mask;
  endtask

  task automatic run(input vec_t v);
    @(negedge clk);
    drive(v);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (!v.mem) begin
      chk("R6 done", {31'b0, done}, 32'd1);
      chk("R6 no req", {31'b0, req}, 32'd0);
      chk("R2 cf", {31'b0, cf}, {31'b0, v.cf});
      chk("R3/R4/R5 word", {16'b0, reg_res}, {16'b0, v.word});
      chk("R6 reg_we", {31'b0, reg_we}, {31'b0, (v.op != 2'd0)});
    end else begin
      chk("R9 read req", {30'b0, req, we}, 32'd2);
      chk("R7/R8 addr", addr, v.addr);
      rdata = v.rdata; ack = 1'b1;
      @(negedge clk);
      ack = 1'b0;
      if (v.op != 2'd0) begin
        chk("R9 write req", {30'b0, req, we}, 32'd3);
        chk("R9 write addr", addr, v.addr);
        chk("R3 wdata", {16'b0, wdata}, {16'b0, v.word});
        chk("R10 no early done", {31'b0, done}, 32'd0);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
      end
      chk("R10 done", {31'b0, done}, 32'd1);
      chk("R9 idle port", {31'b0, req}, 32'd0);
      chk("R2 cf", {31'b0, cf}, {31'b0, v.cf});
      chk("R6 no reg_we on mem", {31'b0, reg_we}, 32'd0);
    end
    @(negedge clk);
    chk("R10 done pulse", {31'b0, done}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1
    chk("R1 reset", {28'b0, done, cf, reg_we, req}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", {28'b0, done, cf, reg_we, req}, 32'd0);

    for (int i = 0; i < NV; i++) run(VECS[i]);

    // R10: start during a memory read is ignored
    @(negedge clk);
    drive(VECS[6]);
    start = 1'b1;
    @(negedge clk);
    chk("R10 busy req", {31'b0, req}, 32'd1);
    op = 2'd1; mem = 1'b0; reg_val = 16'h0000; off_reg = 16'h0000;
    @(negedge clk);
    start = 1'b0;
    chk("R10 start ignored", {30'b0, done, req}, 32'd1);
    chk("R10 addr held", addr, 32'h00001004);
    rdata = 16'h0000; ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    chk("R10 done after ack", {31'b0, done}, 32'd1);
    chk("R2 cf busy case", {31'b0, cf}, 32'd0);
    chk("R6 no reg_we", {31'b0, reg_we}, 32'd0);
    @(negedge clk);
    chk("R10 back idle", {30'b0, done, req}, 32'd0);

    // R1: reset in the middle of a write
    drive(VECS[7]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    rdata = 16'h0000; ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R1 abort", {28'b0, done, cf, reg_we, req}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule